// File: doc/BRIEF.md
# Two-Phase Clock Ordering and Reset Settling Monitor

This block watches a pair of non-overlapping phase clocks and a reset line by sampling them on a faster reference clock. It reports three kinds of misbehaviour through separate flags. The first is two phases that are active together. The second is phases that break the required order, where phase A leads, an optional gap follows, phase B comes next and another optional gap follows. The third is a reset release that is not followed by a quiet settling window. Each flag holds until the monitor is cleared. A one-cycle pulse marks every completed A-then-B cycle, so a designer can count healthy cycles or time them.

The monitored signals must already be synchronous to the reference clock, for example after a synchronizer outside the block. Every reference-clock edge takes one sample. The outputs are registered and show the result of a sample right after the edge that took it. Checking of the phase order pauses while reset is high and for the settling window after it. The overlap check never pauses.

Top module: `phase_pair_monitor`

## Requirements
- R1: A sample with `ph_a` and `ph_b` both high sets `err_overlap` one cycle later. This holds in every state, including during reset and the settling window. The same sample returns the order tracker to its idle state.
- R2: A legal cycle is `ph_a` alone for one or more samples, then both low for zero or more samples, then `ph_b` alone for one or more samples, then both low for zero or more samples. After such a cycle, the next sample with `ph_a` alone raises `cycle_done` for exactly one cycle, with no error flag set.
- R3: After `ph_a` has ended and before `ph_b` has appeared, a sample with `ph_a` alone sets `err_order`.
- R4: After `ph_b` has ended, a sample with `ph_b` alone sets `err_order`. The phase that must come next is `ph_a`.
- R5: In the idle state, samples with `ph_b` alone are ignored and flag nothing. Tracking starts at the first sample with `ph_a` alone, and that first rise does not pulse `cycle_done`.
- R6: After a sample with `sys_rst` high, the next QUIET_CYC (default 3) samples with `sys_rst` low must have both phases low. A phase high in any of them sets `err_reset`. Phase activity on the sample after the window is legal.
- R7: If `sys_rst` returns high inside the settling window, `err_reset` is set.
- R8: While `sys_rst` is high and during the settling window, order errors are not flagged and `cycle_done` stays low. Afterwards, tracking restarts from the idle state.
- R9: All flags are sticky until `mon_clr` is sampled high. `mon_clr` is synchronous and active high, takes priority over every event in the same sample, and clears all outputs and the tracker. After a clear, all four outputs are 0.
- R10: Each condition sets its own flag on its own. A sample that is both an overlap and a window violation sets both `err_overlap` and `err_reset`.
- R11: An order error returns the tracker to idle, so the next `ph_a` rise starts a new cycle and does not pulse `cycle_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| mon_clr | input | 1 | Synchronous active-high clear of flags and tracker |
| sys_rst | input | 1 | Monitored reset line, sampled |
| ph_a | input | 1 | First phase clock, sampled |
| ph_b | input | 1 | Second phase clock, sampled |
| err_overlap | output | 1 | Sticky: phases active together |
| err_order | output | 1 | Sticky: phase order broken |
| err_reset | output | 1 | Sticky: settling window after reset violated |
| cycle_done | output | 1 | One-cycle pulse per completed A-B cycle |

## Verification
The case that is hardest to reach from the ports is a reset that returns inside its own settling window. It needs a reset release, a short low stretch and a re-assertion, all placed before the window counter runs out. The stimulus counts samples exactly from the release. It also places phase activity on the third low sample and on the fourth, to pin the window's closing edge. A second situation is the order tracker holding stale state across a reset. To expose it, the bench leaves the tracker in the phase-A state, pulses reset, and then sends a phase-B-then-A pattern that would complete a cycle only if the state had survived the reset.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_A    = 3'd1,
    ST_GAPA = 3'd2,
    ST_B    = 3'd3,
    ST_GAPB = 3'd4
  } seq_st_t;

  localparam int unsigned FLAG_OVL = 0;
  localparam int unsigned FLAG_ORD = 1;
  localparam int unsigned FLAG_RST = 2;
  localparam int unsigned FLAG_N   = 3;
endpackage

// File: rtl/pcm_seq_track.sv
module pcm_seq_track
  import pcm_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic hold,
  input  logic ph_a,
  input  logic ph_b,
  output logic order_evt,
  output logic done_q
);
  seq_st_t st_q, st_d;
  logic    done_d;
  logic    solo_a, solo_b, both;

  assign solo_a = ph_a & ~ph_b;
  assign solo_b = ph_b & ~ph_a;
  assign both   = ph_a & ph_b;

  always_comb begin
    st_d      = st_q;
    order_evt = 1'b0;
    done_d    = 1'b0;
    if (hold || both) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (solo_a) st_d = ST_A;
        ST_A: begin
          if (solo_b)             st_d = ST_B;
          else if (!ph_a && !ph_b) st_d = ST_GAPA;
        end
        ST_GAPA: begin
          if (solo_b) st_d = ST_B;
          else if (solo_a) begin
            order_evt = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        ST_B: begin
          if (solo_a) begin
            done_d = 1'b1;
            st_d   = ST_A;
          end else if (!ph_a && !ph_b) st_d = ST_GAPB;
        end
        ST_GAPB: begin
          if (solo_a) begin
            done_d = 1'b1;
            st_d   = ST_A;
          end else if (solo_b) begin
            order_evt = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  // R2: a completion leaves the tracker in phase A, so two pulses cannot abut
  a_r2_done_single: assert property (@(posedge clk) disable iff (clr)
    done_q |=> !done_q);

  // R8: no completion is reported for a held sample
  a_r8_hold_no_done: assert property (@(posedge clk) disable iff (clr)
    hold |=> !done_q);
endmodule

// File: rtl/pcm_rst_window.sv
module pcm_rst_window #(
  parameter int unsigned QUIET_CYC = 3
) (
  input  logic clk,
  input  logic clr,
  input  logic rst_in,
  input  logic ph_a,
  input  logic ph_b,
  output logic hold,
  output logic rst_evt
);
  localparam int unsigned CW = $clog2(QUIET_CYC + 1);

  logic          rst_q;
  logic [CW-1:0] cnt_q;
  logic          in_win;

  assign in_win  = !rst_in && (cnt_q != '0);
  assign hold    = rst_in || in_win;
  assign rst_evt = (rst_in && !rst_q && (cnt_q != '0)) ||
                   (in_win && (ph_a || ph_b));

  always_ff @(posedge clk) begin
    rst_q <= rst_in;
    if (clr) begin
      cnt_q <= rst_in ? CW'(QUIET_CYC) : '0;
    end else if (rst_in) begin
      cnt_q <= CW'(QUIET_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R6: the window never lasts longer than the configured count
  a_r6_window_bound: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= CW'(QUIET_CYC));

  // R8: the sample in which reset falls is still held
  a_r8_release_held: assert property (@(posedge clk) disable iff (clr)
    (rst_q && !rst_in) |-> hold);
endmodule

// File: rtl/pcm_sticky.sv
module pcm_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [N-1:0] evt,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (clr) flag[i] <= 1'b0;
      else     flag[i] <= flag[i] | evt[i];
    end

    // R9: a raised flag only drops on a clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (clr)
      flag[i] |=> flag[i]);
  end
endmodule

// File: rtl/phase_pair_monitor.sv
module phase_pair_monitor
  import pcm_pkg::*;
#(
  parameter int unsigned QUIET_CYC = 3
) (
  input  logic clk,
  input  logic mon_clr,
  input  logic sys_rst,
  input  logic ph_a,
  input  logic ph_b,
  output logic err_overlap,
  output logic err_order,
  output logic err_reset,
  output logic cycle_done
);
  logic              hold, rst_evt, order_evt;
  logic [FLAG_N-1:0] evt, flag;

  pcm_rst_window #(.QUIET_CYC(QUIET_CYC)) u_win (
    .clk(clk), .clr(mon_clr), .rst_in(sys_rst),
    .ph_a(ph_a), .ph_b(ph_b), .hold(hold), .rst_evt(rst_evt)
  );

  pcm_seq_track u_seq (
    .clk(clk), .clr(mon_clr), .hold(hold), .ph_a(ph_a), .ph_b(ph_b),
    .order_evt(order_evt), .done_q(cycle_done)
  );

  always_comb begin
    evt           = '0;
    evt[FLAG_OVL] = ph_a & ph_b;
    evt[FLAG_ORD] = order_evt;
    evt[FLAG_RST] = rst_evt;
  end

  pcm_sticky #(.N(FLAG_N)) u_flags (
    .clk(clk), .clr(mon_clr), .evt(evt), .flag(flag)
  );

  assign err_overlap = flag[FLAG_OVL];
  assign err_order   = flag[FLAG_ORD];
  assign err_reset   = flag[FLAG_RST];

  // R1: coincident phases are always flagged
  a_r1_overlap: assert property (@(posedge clk) disable iff (mon_clr)
    (ph_a && ph_b) |=> err_overlap);

  // R2: a completion is always caused by a lone phase-A sample
  a_r2_done_src: assert property (@(posedge clk) disable iff (mon_clr)
    cycle_done |-> $past(ph_a && !ph_b));

  // R6: phase activity on the first sample after release is a violation
  a_r6_first_quiet: assert property (@(posedge clk) disable iff (mon_clr)
    ($past(sys_rst) && !sys_rst && (ph_a || ph_b)) |=> err_reset);

  // R8: no completion while the monitored reset is high
  a_r8_rst_no_done: assert property (@(posedge clk) disable iff (mon_clr)
    sys_rst |=> !cycle_done);
endmodule

// File: tb/phase_pair_monitor_tb_top.sv
module phase_pair_monitor_tb_top;
  logic clk = 1'b0;
  logic mon_clr = 1'b1;
  logic sys_rst = 1'b0;
  logic ph_a = 1'b0;
  logic ph_b = 1'b0;
  logic err_overlap, err_order, err_reset, cycle_done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic eo = 1'b0, eq = 1'b0, er = 1'b0;

  always #10 clk = ~clk;

  phase_pair_monitor #(.QUIET_CYC(3)) dut_i (
    .clk(clk), .mon_clr(mon_clr), .sys_rst(sys_rst), .ph_a(ph_a), .ph_b(ph_b),
    .err_overlap(err_overlap), .err_order(err_order),
    .err_reset(err_reset), .cycle_done(cycle_done)
  );

  // driver: one sample per call; expected {overlap, order, reset, done}
  task automatic step(input logic a, input logic b, input logic r,
                      input logic c, input logic d, input string tag);
    #1;
    ph_a = a; ph_b = b; sys_rst = r; mon_clr = c;
    exp_q.push_back({eo, eq, er, d});
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic clear_all(input string tag);
    eo = 0; eq = 0; er = 0;
    step(0, 0, 0, 1, 0, tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      logic [3:0] e, act;
      string t;
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = {err_overlap, err_order, err_reset, cycle_done};
        n_run++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: got ovl/ord/rst/done=%b expected %b", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(0, 0, 0, 1, 0, "R9 reset state");
    step(0, 0, 0, 1, 0, "R9 reset state");
    // R5: idle ignores lone B, first A rise gives no pulse
    step(0, 1, 0, 0, 0, "R5 lone B in idle");
    step(1, 0, 0, 0, 0, "R5 first A rise");
    step(1, 0, 0, 0, 0, "R2 A held");
    step(0, 0, 0, 0, 0, "R2 gap after A");
    step(0, 1, 0, 0, 0, "R2 B");
    step(0, 0, 0, 0, 0, "R2 gap after B");
    step(1, 0, 0, 0, 1, "R2 completion pulse");
    step(1, 0, 0, 0, 0, "R2 pulse is one cycle");
    step(0, 1, 0, 0, 0, "R2 B with no gap");
    step(1, 0, 0, 0, 1, "R2 completion without gaps");
    // R3
    step(0, 0, 0, 0, 0, "R3 gap after A");
    eq = 1;
    step(1, 0, 0, 0, 0, "R3 A returns before B");
    step(1, 0, 0, 0, 0, "R11 fresh A after order error, no pulse");
    step(0, 1, 0, 0, 0, "R9 order flag sticky");
    clear_all("R9 clear");
    // R4
    step(1, 0, 0, 0, 0, "R4 A");
    step(0, 1, 0, 0, 0, "R4 B");
    step(0, 0, 0, 0, 0, "R4 gap after B");
    eq = 1;
    step(0, 1, 0, 0, 0, "R4 B repeats");
    step(0, 0, 0, 0, 0, "R9 sticky after R4");
    clear_all("R9 clear");
    // R1
    step(1, 0, 0, 0, 0, "R1 A");
    eo = 1;
    step(1, 1, 0, 0, 0, "R1 overlap");
    step(0, 1, 0, 0, 0, "R1 idle after overlap");
    step(1, 0, 0, 0, 0, "R1 restart no pulse");
    clear_all("R9 clear");
    // R8: tracker state lost across reset
    step(1, 0, 0, 0, 0, "R8 A before reset");
    step(0, 0, 1, 0, 0, "R8 reset high");
    step(0, 0, 1, 0, 0, "R8 reset high");
    step(0, 0, 0, 0, 0, "R6 window 1");
    step(0, 0, 0, 0, 0, "R6 window 2");
    step(0, 0, 0, 0, 0, "R6 window 3");
    step(0, 1, 0, 0, 0, "R8 lone B after window ignored");
    step(1, 0, 0, 0, 0, "R8 no stale completion");
    // R8: phases inside reset are not order-checked
    step(1, 0, 1, 0, 0, "R8 A during reset");
    step(0, 0, 1, 0, 0, "R8 gap during reset");
    step(1, 0, 1, 0, 0, "R8 A again during reset");
    step(0, 0, 0, 0, 0, "R6 window 1");
    step(0, 0, 0, 0, 0, "R6 window 2");
    er = 1;
    step(1, 0, 0, 0, 0, "R6 A on last window sample");
    step(0, 0, 0, 0, 0, "R9 reset flag sticky");
    clear_all("R9 clear");
    // R6 boundary: fourth sample is legal
    step(0, 0, 1, 0, 0, "R6 reset");
    step(0, 0, 0, 0, 0, "R6 window 1");
    step(0, 0, 0, 0, 0, "R6 window 2");
    step(0, 0, 0, 0, 0, "R6 window 3");
    step(1, 0, 0, 0, 0, "R6 A after window legal");
    // R7
    step(0, 0, 1, 0, 0, "R7 reset");
    step(0, 0, 0, 0, 0, "R7 window 1");
    er = 1;
    step(0, 0, 1, 0, 0, "R7 reset returns in window");
    step(0, 0, 0, 0, 0, "R7 sticky");
    clear_all("R9 clear");
    // R10
    step(0, 0, 1, 0, 0, "R10 reset");
    step(0, 0, 0, 0, 0, "R10 window 1");
    eo = 1; er = 1;
    step(1, 1, 0, 0, 0, "R10 overlap inside window");
    // R9: clear wins over a same-sample overlap
    eo = 0; eq = 0; er = 0;
    step(1, 1, 0, 1, 0, "R9 clear priority");
    step(0, 0, 0, 0, 0, "R9 clean after clear");
    repeat (3) @(posedge clk);
    #5;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule